// File: doc/BRIEF.md
# External Bus Tenure Client

This block lets a local memory-access engine obtain, use and give back a shared external bus that several masters reach through an outside arbiter. It raises an active-low request towards the arbiter whenever the engine has an external access pending, or whenever a software hold bit is set. It takes mastership only once the arbiter's active-low grant is present and the shared active-low busy line has been seen free. It then drives busy low for as long as it owns the bus.

Each bus cycle is started with a one-clock strobe to the engine and closed by the engine's done pulse. If the grant is withdrawn, the bus is handed back only between cycles, never inside one. If the grant stays present after the work is finished, the block parks: it keeps busy low and can resume without arbitrating again. The bus is handed back by driving busy high for a single clock and then turning the driver off, so that the external pull-up holds the line high. An asynchronous mode runs grant and busy through a synchronizer chain before the state machine uses them.

Top module: `bus_tenure_client`

## Requirements
- R1: `bus_req_n` is a registered, always-driven output. It is low in the cycle after one in which `eng_req` or `cfg_hold_req` was high, and high otherwise.
- R2: With `cfg_hold_req` high and `eng_req` low, the block requests the bus and takes it when granted, but parks without ever pulsing `eng_start`.
- R3: The block drives busy only after two conditions have held at the same clock edge, while it waits: grant was seen low and the busy line was seen high. From the following cycle `bus_busy_oe`=1 and `bus_busy_n_out`=0, and this never happens while another master holds busy low.
- R4: `eng_start` is high only while the block is master, is granted, has `eng_req` high and has no bus cycle open. A cycle opens on the clock edge where `eng_start` is high and closes on the clock edge where `eng_done` is high. `eng_done` has no effect when no cycle is open.
- R5: If the grant is withdrawn while a cycle is open, busy stays driven low until that cycle closes, and the release follows after it. A multi-access burst therefore loses the bus between accesses.
- R6: Parking: when the accesses end and grant stays low, busy stays driven low. A new `eng_req` then starts a cycle with no busy release and no new arbitration.
- R7: Release: when the grant is gone and no cycle is open, the block drives `bus_busy_n_out`=1 with `bus_busy_oe`=1 for exactly one cycle. After that, `bus_busy_oe`=0.
- R8: Reset state: `bus_req_n`=1, `bus_busy_oe`=0, `eng_start`=0, and the block is a slave.
- R9: With `cfg_async_en`=1, grant and busy each pass through SYNC_STAGES flops before use. The same response as in R3 to R7 then arrives SYNC_STAGES cycles later.
- R10: If the grant is withdrawn while the block is still waiting for a free busy line, it returns to slave without ever driving busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_async_en | input | 1 | 1: treat grant and busy as asynchronous inputs and synchronize them |
| cfg_hold_req | input | 1 | Software hold: keep requesting the bus with no access pending |
| eng_req | input | 1 | Engine has an external access pending |
| eng_done | input | 1 | Engine pulse: the open bus cycle ends |
| eng_start | output | 1 | Strobe: start one bus cycle now |
| bus_req_n | output | 1 | Active-low bus request to the arbiter |
| bus_grant_n | input | 1 | Active-low bus grant from the arbiter |
| bus_busy_n_in | input | 1 | Sampled level of the shared busy line |
| bus_busy_n_out | output | 1 | Level driven onto the busy line |
| bus_busy_oe | output | 1 | Busy-line driver enable |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. It switches `cfg_async_en` at run time, so the same scenario list runs once with direct sampling and once with a two-flop latency on grant and busy. It models the busy line as a wired-AND of the block's driver and another master. This brings contention into reach: busy held by another master, grant lost in the middle of a burst, grant withdrawn while waiting, and parking with a resumed access.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    ST_SLAVE     = 3'd0,
    ST_WAIT_FREE = 3'd1,
    ST_ACTIVE    = 3'd2,
    ST_PARKED    = 3'd3,
    ST_RELEASE   = 3'd4
  } bt_state_e;

  // A bus request is raised for a real access or for the software hold.
  function automatic logic wants_bus(input logic req, input logic hold);
    return req | hold;
  endfunction

  // States in which the busy driver is enabled.
  function automatic logic owns_line(input bt_state_e s);
    return (s == ST_ACTIVE) || (s == ST_PARKED) || (s == ST_RELEASE);
  endfunction
endpackage

// File: rtl/bt_in_sync.sv
module bt_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_en,
  input  logic din_n,
  output logic dout_n
);
  generate
    if (STAGES == 0) begin : g_bypass
      logic unused_ok;
      assign unused_ok = clk ^ rst_n ^ async_en;
      assign dout_n = din_n;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= '1;
        end else begin
          sh_q[0] <= din_n;
          for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
        end
      end
      assign dout_n = async_en ? sh_q[STAGES-1] : din_n;
    end
  endgenerate
endmodule

// File: rtl/bt_arb_fsm.sv
module bt_arb_fsm
  import bt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      eng_req,
  input  logic      hold_req,
  input  logic      eng_done,
  input  logic      granted,
  input  logic      busy_seen,
  output bt_state_e state_q,
  output logic      cyc_open,
  output logic      eng_start
);
  bt_state_e state_d;
  logic      open_q, open_d;

  assign eng_start = (state_q == ST_ACTIVE) && !open_q && granted && eng_req;
  assign cyc_open  = open_q;

  always_comb begin
    state_d = state_q;
    open_d  = open_q;
    unique case (state_q)
      ST_SLAVE:
        if (granted && wants_bus(eng_req, hold_req)) state_d = ST_WAIT_FREE;
      ST_WAIT_FREE:
        if (!granted)        state_d = ST_SLAVE;
        else if (!busy_seen) state_d = eng_req ? ST_ACTIVE : ST_PARKED;
      ST_ACTIVE:
        if (open_q) begin
          if (eng_done) open_d = 1'b0;
        end else if (eng_start) begin
          open_d = 1'b1;
        end else if (!granted) begin
          state_d = ST_RELEASE;
        end else if (!eng_req) begin
          state_d = ST_PARKED;
        end
      ST_PARKED:
        if (!granted)     state_d = ST_RELEASE;
        else if (eng_req) state_d = ST_ACTIVE;
      ST_RELEASE:
        state_d = ST_SLAVE;
      default:
        state_d = ST_SLAVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SLAVE;
      open_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      open_q  <= open_d;
    end
  end

  // R4: a start needs an owned, granted bus and no open cycle
  a_r4_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (granted && !open_q && state_q == ST_ACTIVE));
  // R5: an open cycle keeps the block active even with the grant gone
  a_r5_hold_through_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !granted) |=> (state_q == ST_ACTIVE));
  // R3: a busy line seen asserted blocks the takeover
  a_r3_wait_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_FREE && busy_seen) |=> (state_q == ST_WAIT_FREE || state_q == ST_SLAVE));
  // R6: a parked master with grant keeps the bus
  a_r6_park_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PARKED && granted) |=> (state_q == ST_PARKED || state_q == ST_ACTIVE));
endmodule

// File: rtl/bt_busy_drv.sv
module bt_busy_drv
  import bt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bt_state_e state_q,
  output logic      busy_oe,
  output logic      busy_n_out
);
  assign busy_oe    = owns_line(state_q);
  assign busy_n_out = (state_q == ST_RELEASE);

  // R7: the high drive lasts one clock, then the driver is off
  a_r7_pullup_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_oe && busy_n_out) |=> !busy_oe);
endmodule

// File: rtl/bus_tenure_client.sv
module bus_tenure_client
  import bt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_async_en,
  input  logic cfg_hold_req,
  input  logic eng_req,
  input  logic eng_done,
  output logic eng_start,
  output logic bus_req_n,
  input  logic bus_grant_n,
  input  logic bus_busy_n_in,
  output logic bus_busy_n_out,
  output logic bus_busy_oe
);
  logic      grant_n_s, busy_n_s;
  logic      granted, busy_seen;
  logic      req_q, cyc_open;
  bt_state_e state_q;

  bt_in_sync #(.STAGES(SYNC_STAGES)) u_sync_grant (
    .clk(clk), .rst_n(rst_n), .async_en(cfg_async_en),
    .din_n(bus_grant_n), .dout_n(grant_n_s));

  bt_in_sync #(.STAGES(SYNC_STAGES)) u_sync_busy (
    .clk(clk), .rst_n(rst_n), .async_en(cfg_async_en),
    .din_n(bus_busy_n_in), .dout_n(busy_n_s));

  assign granted   = !grant_n_s;
  assign busy_seen = !busy_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= wants_bus(eng_req, cfg_hold_req);
  end
  assign bus_req_n = !req_q;

  bt_arb_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .hold_req(cfg_hold_req),
    .eng_done(eng_done), .granted(granted), .busy_seen(busy_seen),
    .state_q(state_q), .cyc_open(cyc_open), .eng_start(eng_start));

  bt_busy_drv u_drv (
    .clk(clk), .rst_n(rst_n), .state_q(state_q),
    .busy_oe(bus_busy_oe), .busy_n_out(bus_busy_n_out));

  // R3: taking the line happens only after a free busy line was seen
  a_r3_take_after_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy_oe) |-> $past(!busy_seen && granted));
  // R4: no new start while a cycle is open
  a_r4_single_open: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_open |-> !eng_start);
  // R2: with no access pending, no start is issued
  a_r2_no_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_req |-> !eng_start);
endmodule

// File: tb/bus_tenure_client_tb_top.sv
module bus_tenure_client_tb_top;
  localparam int STG = 2;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_async_en = 1'b0, cfg_hold_req = 1'b0, eng_req = 1'b0, eng_done = 1'b0;
  logic bus_grant_n = 1'b1, ext_busy_n = 1'b1;
  logic eng_start, bus_req_n, bus_busy_n_out, bus_busy_oe, bus_busy_n_in;

  always #4 clk = ~clk;

  assign bus_busy_n_in = (bus_busy_oe ? bus_busy_n_out : 1'b1) & ext_busy_n;

  bus_tenure_client #(.SYNC_STAGES(STG)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_async_en(cfg_async_en), .cfg_hold_req(cfg_hold_req),
    .eng_req(eng_req), .eng_done(eng_done), .eng_start(eng_start), .bus_req_n(bus_req_n),
    .bus_grant_n(bus_grant_n), .bus_busy_n_in(bus_busy_n_in),
    .bus_busy_n_out(bus_busy_n_out), .bus_busy_oe(bus_busy_oe));

  int checks = 0, errors = 0;
  string tag = "R8";

  // Behavioural reference: 0 slave,1 waiting,2 active,3 parked,4 releasing
  int   ms = 0;
  bit   mopen = 0, mreq = 0;
  bit   gq[$], bq[$];
  bit   prev_req = 0;

  function automatic bit m_granted();
    return cfg_async_en ? !gq[STG-1] : !bus_grant_n;
  endfunction
  function automatic bit m_busy();
    return cfg_async_en ? !bq[STG-1] : !bus_busy_n_in;
  endfunction
  function automatic bit m_start();
    return ms == 2 && !mopen && m_granted() && eng_req;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mopen = 0; mreq = 0;
      gq.delete(); bq.delete();
      for (int i = 0; i < STG; i++) begin gq.push_back(1'b1); bq.push_back(1'b1); end
    end else begin
      bit g, b, s;
      g = m_granted(); b = m_busy(); s = m_start();
      case (ms)
        0: if (g && (eng_req || cfg_hold_req)) ms = 1;
        1: if (!g) ms = 0; else if (!b) ms = eng_req ? 2 : 3;
        2: if (mopen) begin if (eng_done) mopen = 0; end
           else if (s) mopen = 1;
           else if (!g) ms = 4;
           else if (!eng_req) ms = 3;
        3: if (!g) ms = 4; else if (eng_req) ms = 2;
        default: ms = 0;
      endcase
      mreq = eng_req || cfg_hold_req;
      gq.push_front(bus_grant_n); void'(gq.pop_back());
      bq.push_front(bus_busy_n_in); void'(bq.pop_back());
    end
  end

  task automatic check(input string rq, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", rq, what, act, exp, $time);
    end
  endtask

  // Stimulus engine: pending accesses and a done LAT cycles into each open cycle
  int left = 0, age = 0, starts = 0;
  logic n_grant_n = 1'b1, n_ext_n = 1'b1, n_hold = 1'b0, n_async = 1'b0;

  task automatic step();
    @(negedge clk);
    if (eng_done) left--;
    age = mopen ? age + 1 : 0;
    eng_done = (age == LAT);
    eng_req = (left > 0);
    bus_grant_n = n_grant_n; ext_busy_n = n_ext_n;
    cfg_hold_req = n_hold; cfg_async_en = n_async;
    #1;
    check("R1", "bus_req_n", bus_req_n, !mreq);
    check(tag, "bus_busy_oe", bus_busy_oe, ms != 0 && ms != 1);
    check(tag, "bus_busy_n_out", bus_busy_n_out, ms == 4);
    check("R4", "eng_start", eng_start, m_start());
    if (eng_start) starts++;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic scenarios(input bit async_mode);
    n_async = async_mode;
    // R2: hold only, grant, park, then give up
    tag = async_mode ? "R9" : "R2";
    starts = 0; n_hold = 1; steps(3);
    check("R1", "request on hold", bus_req_n, 1'b0);
    n_grant_n = 0; steps(6);
    check("R2", "parked by hold", bus_busy_oe, 1'b1);
    check("R2", "no start on hold", starts != 0, 1'b0);
    tag = async_mode ? "R9" : "R7";
    n_grant_n = 1; n_hold = 0; steps(8);
    check("R7", "driver off after release", bus_busy_oe, 1'b0);
    // R3: another master holds busy
    tag = async_mode ? "R9" : "R3";
    n_ext_n = 0; left = 2; n_grant_n = 0; steps(6);
    check("R3", "no drive while busy held", bus_busy_oe, 1'b0);
    n_ext_n = 1; steps(4 * LAT + 12);
    check("R4", "two accesses two starts", starts == 2, 1'b1);
    // R6: parked, resume without release
    tag = async_mode ? "R9" : "R6";
    check("R6", "parked holds busy", bus_busy_oe && !bus_busy_n_out, 1'b1);
    left = 1; steps(2 * LAT + 6);
    check("R6", "resumed access started", starts == 3, 1'b1);
    n_grant_n = 1; steps(8);
    // R5: grant lost inside a burst
    tag = async_mode ? "R9" : "R5";
    starts = 0; left = 3; n_grant_n = 0;
    for (int i = 0; i < 40 && starts == 0; i++) step();
    n_grant_n = 1; steps(LAT + 8);
    check("R5", "burst cut between accesses", starts == 1, 1'b1);
    check("R5", "bus given back", bus_busy_oe, 1'b0);
    left = 0; steps(2);
    // R10: grant withdrawn while waiting
    tag = async_mode ? "R9" : "R10";
    n_ext_n = 0; left = 1; n_grant_n = 0; steps(5);
    n_grant_n = 1; steps(5);
    n_ext_n = 1; steps(5);
    check("R10", "never drove busy", bus_busy_oe, 1'b0);
    left = 0; steps(3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8", "bus_req_n in reset", bus_req_n, 1'b1);
    check("R8", "busy driver in reset", bus_busy_oe, 1'b0);
    check("R8", "eng_start in reset", eng_start, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    steps(2);
    scenarios(1'b0);
    scenarios(1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule